// File: doc/BRIEF.md
# Asynchronous DRAM timing controller

This block sits between a synchronous host and an asynchronous DRAM whose row and column addresses share one set of address pins. A host request carries a flat address, a read/write flag and write data. The controller splits the address into a row part and a column part and drives them onto the shared bus in turn. It lowers the row strobe and then the column strobe with the required setup and hold margins around each falling edge. It returns read data together with a single-cycle completion pulse. Every minimum interval is counted in whole clock cycles and set by a parameter.

A free-running interval timer raises refresh requests, and these win over host traffic at the next idle point. A style input chooses the refresh form. One form pulses the row strobe alone with an internally counted row address. The other lowers the column strobe first and the row strobe after it. Cell storage is outside the block, and only single accesses are issued.

Top module: `dram_ctl`

## Requirements
- R1: After reset the row strobe, column strobe, write enable and output enable are all high (inactive), the done pulse is low, and the host ready is high.
- R2: For every access, the address bus holds the same value for at least T_SETUP cycles before a strobe falls and for at least T_HOLD cycles starting at that fall. This applies to the row strobe in accesses and row-only refreshes, and to the column strobe in accesses.
- R3: The row strobe stays low for at least T_RAS cycles each time it falls, and stays high for at least T_RP cycles before it falls again.
- R4: In an access the column strobe stays low for at least T_CAS cycles, and it is high for at least T_CP cycles before any fall.
- R5: In a write, write enable is low in the cycle before the column strobe falls and stays low until the column strobe rises. Write enable changes only while the column strobe is high. The data bus is driven with the host write data when the column strobe falls.
- R6: Output enable is low only during a read while both strobes are low. The returned read data is the data the memory presents at least T_RD cycles after the column strobe fell.
- R7: Each access ends with both strobes rising at the same clock edge. The done output is high for exactly one cycle, which is the first cycle with both strobes high.
- R8: A refresh becomes due every REF_INTERVAL cycles. With no host traffic, refreshes start exactly REF_INTERVAL cycles apart. Under continuous host traffic a due refresh starts before any further access, so consecutive refreshes are never more than REF_INTERVAL + 16 cycles apart.
- R9: When the style input is 0, a refresh drives the refresh row on the address bus and lowers the row strobe while the column strobe stays high. The refresh row starts at 0 after reset and increases by one, modulo 2^ROW_W, after each such refresh.
- R10: When the style input is 1, a refresh lowers the column strobe at least T_CSR cycles before the row strobe falls. The column strobe then stays low for at least T_CHR cycles after that fall. Write enable and output enable stay high throughout.
- R11: The row address is host address bits [ROW_W+COL_W-1:COL_W] and the column address is bits [COL_W-1:0]. Both are driven on the low bits of the address bus, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present; held until accepted |
| req_ready_o | output | 1 | Request is accepted at an edge where valid and ready are both high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Flat host address, row part in the upper bits |
| req_wdata_i | input | DATA_W | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, valid while done is high |
| ref_style_i | input | 1 | 0 = row-only refresh, 1 = column-first refresh |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_dq_o | output | DATA_W | Write data toward memory |
| dram_dq_oe_o | output | 1 | High while the controller drives the data bus |
| dram_dq_i | input | DATA_W | Read data from memory |

## Verification
The sequencer state decides every strobe level, so a wrong state or phase counter appears within one cycle as a strobe pulse or gap that is too short. It can also appear as an address that changes inside a setup or hold window, or as a done pulse that does not line up with the strobes rising. A corrupted refresh row counter shows up at the next row-only refresh as an unexpected value on the address bus. A wrong refresh timer shows up as a change in the spacing between refresh starts when there is no host traffic. Bad data capture or a swapped address split shows up on the next read of that location as a data mismatch.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW_SET,
        S_ROW_HOLD,
        S_COL_SET,
        S_COL_ACT,
        S_RREF,
        S_CLEAD,
        S_CREF,
        S_PRECH
    } seq_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int REF_INTERVAL = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic take_i,
    output logic due_o
);
    localparam int CW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (int'(tmr_q.cnt) == REF_INTERVAL - 1) begin
            tmr_d.cnt = '0;
            tmr_d.due = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
            if (take_i) tmr_d.due = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign due_o = tmr_q.due;

    // A due refresh is only withdrawn by the sequencer taking it
    assert_due_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (due_o && !take_i) |=> due_o);

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq import dram_ctl_pkg::*; #(
    parameter int ROW_W   = 5,
    parameter int COL_W   = 5,
    parameter int DATA_W  = 8,
    parameter int T_SETUP = 1,
    parameter int T_HOLD  = 2,
    parameter int T_RAS   = 6,
    parameter int T_RP    = 3,
    parameter int T_CAS   = 2,
    parameter int T_CP    = 2,
    parameter int T_RD    = 2,
    parameter int T_CSR   = 2,
    parameter int T_CHR   = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     ref_due_i,
    output logic                     ref_take_o,
    input  logic                     ref_style_i,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic                     req_write_i,
    input  logic [ROW_W+COL_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    output logic                     rsp_done_o,
    output logic [DATA_W-1:0]        rsp_rdata_o,
    output logic                     dram_ras_n_o,
    output logic                     dram_cas_n_o,
    output logic                     dram_we_n_o,
    output logic                     dram_oe_n_o,
    output logic [max2(ROW_W,COL_W)-1:0] dram_addr_o,
    output logic [DATA_W-1:0]        dram_dq_o,
    output logic                     dram_dq_oe_o,
    input  logic [DATA_W-1:0]        dram_dq_i
);
    localparam int MA_W     = max2(ROW_W, COL_W);
    localparam int CACT_LEN = max2(max2(T_CAS, T_RD), max2(T_HOLD, T_RAS - T_HOLD - T_SETUP));
    localparam int RREF_LEN = max2(T_RAS, T_HOLD);
    localparam int CREF_LEN = max2(T_RAS, T_CHR);
    localparam int PRE_LEN  = max2(T_RP, T_CP);
    localparam int LONGEST  = max2(max2(max2(CACT_LEN, RREF_LEN), max2(CREF_LEN, PRE_LEN)),
                                   max2(max2(T_SETUP, T_HOLD), T_CSR));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              is_ref;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic [ROW_W-1:0]  ref_row;
    } seq_t;

    seq_t seq_q, seq_d;
    int   phase_len;
    logic phase_end;

    always_comb begin
        case (seq_q.st)
            S_ROW_SET:  phase_len = T_SETUP;
            S_ROW_HOLD: phase_len = T_HOLD;
            S_COL_SET:  phase_len = T_SETUP;
            S_COL_ACT:  phase_len = CACT_LEN;
            S_RREF:     phase_len = RREF_LEN;
            S_CLEAD:    phase_len = T_CSR;
            S_CREF:     phase_len = CREF_LEN;
            S_PRECH:    phase_len = PRE_LEN;
            default:    phase_len = 1;
        endcase
        phase_end = (int'(seq_q.cnt) == phase_len - 1);
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ref_take_o = 1'b0;
        if (seq_q.st == S_IDLE) begin
            seq_d.cnt = '0;
            if (ref_due_i) begin
                ref_take_o   = 1'b1;
                seq_d.is_ref = 1'b1;
                seq_d.wr     = 1'b0;
                seq_d.row    = seq_q.ref_row;
                seq_d.st     = ref_style_i ? S_CLEAD : S_ROW_SET;
            end else if (req_valid_i) begin
                seq_d.is_ref = 1'b0;
                seq_d.wr     = req_write_i;
                seq_d.row    = req_addr_i[ROW_W+COL_W-1:COL_W];
                seq_d.col    = req_addr_i[COL_W-1:0];
                seq_d.wdata  = req_wdata_i;
                seq_d.st     = S_ROW_SET;
            end
        end else if (!phase_end) begin
            seq_d.cnt = seq_q.cnt + CNT_W'(1);
        end else begin
            seq_d.cnt = '0;
            case (seq_q.st)
                S_ROW_SET:  seq_d.st = seq_q.is_ref ? S_RREF : S_ROW_HOLD;
                S_ROW_HOLD: seq_d.st = S_COL_SET;
                S_COL_SET:  seq_d.st = S_COL_ACT;
                S_COL_ACT: begin
                    seq_d.st   = S_PRECH;
                    seq_d.done = 1'b1;
                    if (!seq_q.wr) seq_d.rdata = dram_dq_i;
                end
                S_RREF: begin
                    seq_d.st      = S_PRECH;
                    seq_d.ref_row = seq_q.ref_row + ROW_W'(1);
                end
                S_CLEAD:    seq_d.st = S_CREF;
                S_CREF:     seq_d.st = S_PRECH;
                default:    seq_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    // Pin decode from the registered phase
    logic row_phase, col_phase, ras_low, cas_low;
    always_comb begin
        row_phase = (seq_q.st == S_ROW_SET) || (seq_q.st == S_ROW_HOLD) || (seq_q.st == S_RREF);
        col_phase = (seq_q.st == S_COL_SET) || (seq_q.st == S_COL_ACT);
        ras_low   = (seq_q.st == S_ROW_HOLD) || col_phase || (seq_q.st == S_RREF) ||
                    (seq_q.st == S_CREF);
        cas_low   = (seq_q.st == S_COL_ACT) || (seq_q.st == S_CLEAD) || (seq_q.st == S_CREF);
    end

    assign dram_ras_n_o = !ras_low;
    assign dram_cas_n_o = !cas_low;
    assign dram_we_n_o  = !(seq_q.wr && col_phase);
    assign dram_oe_n_o  = !(!seq_q.wr && (seq_q.st == S_COL_ACT));
    assign dram_dq_oe_o = seq_q.wr && col_phase;
    assign dram_dq_o    = seq_q.wdata;
    assign dram_addr_o  = row_phase ? MA_W'(seq_q.row) :
                          col_phase ? MA_W'(seq_q.col) : '0;
    assign req_ready_o  = (seq_q.st == S_IDLE) && !ref_due_i;
    assign rsp_done_o   = seq_q.done;
    assign rsp_rdata_o  = seq_q.rdata;

    assert_oe_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dram_oe_n_o |-> (!dram_ras_n_o && !dram_cas_n_o && dram_we_n_o));

    assert_done_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_done_o |=> !rsp_done_o);

    assert_release_together_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dram_cas_n_o) |-> $rose(dram_ras_n_o));

    assert_we_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dram_cas_n_o && !$past(dram_cas_n_o)) |-> $stable(dram_we_n_o));

    assert_ras_precharge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dram_ras_n_o) |=> dram_ras_n_o);

    assert_cbr_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dram_cas_n_o && dram_ras_n_o) |-> (dram_we_n_o && dram_oe_n_o));

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl import dram_ctl_pkg::*; #(
    parameter int ROW_W        = 5,
    parameter int COL_W        = 5,
    parameter int DATA_W       = 8,
    parameter int T_SETUP      = 1,
    parameter int T_HOLD       = 2,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 3,
    parameter int T_CAS        = 2,
    parameter int T_CP         = 2,
    parameter int T_RD         = 2,
    parameter int T_CSR        = 2,
    parameter int T_CHR        = 8,
    parameter int REF_INTERVAL = 100
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         req_valid_i,
    output logic                         req_ready_o,
    input  logic                         req_write_i,
    input  logic [ROW_W+COL_W-1:0]       req_addr_i,
    input  logic [DATA_W-1:0]            req_wdata_i,
    output logic                         rsp_done_o,
    output logic [DATA_W-1:0]            rsp_rdata_o,
    input  logic                         ref_style_i,
    output logic                         dram_ras_n_o,
    output logic                         dram_cas_n_o,
    output logic                         dram_we_n_o,
    output logic                         dram_oe_n_o,
    output logic [max2(ROW_W,COL_W)-1:0] dram_addr_o,
    output logic [DATA_W-1:0]            dram_dq_o,
    output logic                         dram_dq_oe_o,
    input  logic [DATA_W-1:0]            dram_dq_i
);
    logic ref_due, ref_take;

    dram_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .take_i (ref_take),
        .due_o  (ref_due)
    );

    dram_access_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .T_RAS(T_RAS), .T_RP(T_RP),
        .T_CAS(T_CAS), .T_CP(T_CP), .T_RD(T_RD), .T_CSR(T_CSR), .T_CHR(T_CHR)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ref_due_i    (ref_due),
        .ref_take_o   (ref_take),
        .ref_style_i  (ref_style_i),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_write_i  (req_write_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .rsp_done_o   (rsp_done_o),
        .rsp_rdata_o  (rsp_rdata_o),
        .dram_ras_n_o (dram_ras_n_o),
        .dram_cas_n_o (dram_cas_n_o),
        .dram_we_n_o  (dram_we_n_o),
        .dram_oe_n_o  (dram_oe_n_o),
        .dram_addr_o  (dram_addr_o),
        .dram_dq_o    (dram_dq_o),
        .dram_dq_oe_o (dram_dq_oe_o),
        .dram_dq_i    (dram_dq_i)
    );

endmodule

// File: tb/tb_dram_ctl.sv
`timescale 1ns/1ps
module tb_dram_ctl;
    localparam int ROW_W = 5, COL_W = 5, DATA_W = 8;
    localparam int T_SETUP = 1, T_HOLD = 2, T_RAS = 6, T_RP = 3, T_CAS = 2, T_CP = 2;
    localparam int T_RD = 2, T_CSR = 2, T_CHR = 8, REF_INTERVAL = 100;
    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int AW = ROW_W + COL_W;
    localparam int SLACK = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic req_valid = 1'b0, req_write = 1'b0, style = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0, dq_i = '0;
    logic ready, done, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [DATA_W-1:0] rdata, dq_o;
    logic [MA_W-1:0] ma;

    dram_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_SETUP(T_SETUP),
        .T_HOLD(T_HOLD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RD(T_RD), .T_CSR(T_CSR), .T_CHR(T_CHR), .REF_INTERVAL(REF_INTERVAL)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
        .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_done_o(done), .rsp_rdata_o(rdata), .ref_style_i(style),
        .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_oe_n_o(oe_n),
        .dram_addr_o(ma), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i));

    int tests = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model and shadow
    logic [DATA_W-1:0] cells [1 << AW];
    logic [DATA_W-1:0] shadow [1 << AW];
    logic [ROW_W-1:0] m_row;
    logic [COL_W-1:0] m_col;

    // host-side context shared with the monitor
    bit accepted = 0, cur_wr = 0, style_stable = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [DATA_W-1:0] cur_wdata = '0;
    logic [ROW_W-1:0] exp_row = '0;
    int ref_count = 0, last_ref = 0, last_gap = 0, cyc = 0;
    bit have_ref = 0;

    function automatic logic [MA_W-1:0] row_of(input logic [AW-1:0] a);
        return MA_W'(a[AW-1:COL_W]);
    endfunction
    function automatic logic [MA_W-1:0] col_of(input logic [AW-1:0] a);
        return MA_W'(a[COL_W-1:0]);
    endfunction

    logic p_ras = 1, p_cas = 1, p_we = 1, p_done = 0;
    logic [MA_W-1:0] p_ma = '0, hold_val = '0;
    int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0, ma_run = 0, hold_left = 0;
    bit seen_ras = 0, seen_cas = 0, in_rowref = 0;

    task automatic note_ref(input bit cbr);
        if (have_ref) begin
            last_gap = cyc - last_ref;
            chk(last_gap <= REF_INTERVAL + SLACK, "R8", "refresh spacing", last_gap,
                REF_INTERVAL + SLACK);
        end
        have_ref = 1;
        last_ref = cyc;
        ref_count++;
        if (style_stable) chk(style == cbr, cbr ? "R10" : "R9", "refresh form", cbr, style);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            ma_run = (ma == p_ma) ? ma_run + 1 : 1;
            if (hold_left > 0) begin
                chk(ma == hold_val, "R2", "address hold", ma, hold_val);
                hold_left--;
            end
            // row strobe fall
            if (p_ras && !ras_n) begin
                if (seen_ras) chk(ras_hi >= T_RP, "R3", "row precharge", ras_hi, T_RP);
                seen_ras = 1;
                m_row = ma[ROW_W-1:0];
                if (cas_n) begin
                    chk(ma_run >= T_SETUP + 1, "R2", "row setup", ma_run - 1, T_SETUP);
                    hold_left = T_HOLD - 1;
                    hold_val = ma;
                    if (accepted) chk(ma == row_of(cur_addr), "R11", "row part", ma, row_of(cur_addr));
                    else begin
                        chk(ma == MA_W'(exp_row), "R9", "refresh row", ma, exp_row);
                        exp_row = exp_row + ROW_W'(1);
                        in_rowref = 1;
                        note_ref(0);
                    end
                end else begin
                    chk(cas_lo >= T_CSR, "R10", "column lead", cas_lo, T_CSR);
                end
            end
            // row strobe rise
            if (!p_ras && ras_n) begin
                chk(ras_lo >= T_RAS, "R3", "row active", ras_lo, T_RAS);
                chk(cas_n == 1'b1, "R7", "strobes released together", cas_n, 1);
                in_rowref = 0;
            end
            if (in_rowref && !cas_n) chk(0, "R9", "column strobe in row-only refresh", 0, 1);
            // column strobe fall
            if (p_cas && !cas_n) begin
                if (seen_cas) chk(cas_hi >= T_CP, "R4", "column precharge", cas_hi, T_CP);
                seen_cas = 1;
                if (!ras_n) begin
                    m_col = ma[COL_W-1:0];
                    chk(ma_run >= T_SETUP + 1, "R2", "column setup", ma_run - 1, T_SETUP);
                    hold_left = T_HOLD - 1;
                    hold_val = ma;
                    chk(ma == col_of(cur_addr), "R11", "column part", ma, col_of(cur_addr));
                    if (cur_wr) begin
                        chk(p_we == 1'b0, "R5", "write enable before column", p_we, 0);
                        chk(dq_oe && dq_o == cur_wdata, "R5", "write data", dq_o, cur_wdata);
                        cells[{m_row, m_col}] = dq_o;
                    end else chk(p_we == 1'b1, "R5", "no write enable on read", p_we, 1);
                end else begin
                    chk(we_n && oe_n, "R10", "enables idle in refresh", {we_n, oe_n}, 3);
                    note_ref(1);
                end
            end
            // column strobe rise
            if (!p_cas && cas_n) begin
                if (accepted) chk(cas_lo >= T_CAS, "R4", "column active", cas_lo, T_CAS);
                else chk(ras_lo >= T_CHR, "R10", "column hold after row", ras_lo, T_CHR);
            end
            if (we_n != p_we) chk(cas_n == 1'b1, "R5", "write enable change with column low", cas_n, 1);
            if (!oe_n) chk(!ras_n && !cas_n && we_n && !cur_wr, "R6", "output enable window", 0, 1);
            if (done) chk(ras_n && cas_n && !p_ras && !p_cas, "R7", "done at release",
                          {p_ras, p_cas, ras_n, cas_n}, 3);
            if (p_done) chk(!done, "R7", "done width", done, 0);
            // run lengths include the current sample
            if (ras_n) begin ras_hi++; ras_lo = 0; end else begin ras_lo++; ras_hi = 0; end
            if (cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
            dq_i = (!oe_n && !cas_n && cas_lo >= T_RD) ? cells[{m_row, m_col}] : 8'hEE;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ma = ma; p_done = done;
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
        int guard;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        cur_wr = wr; cur_addr = a; cur_wdata = d;
        guard = 0;
        while (!ready && guard < 200) begin @(negedge clk); guard++; end
        accepted = 1;
        @(negedge clk);
        req_valid = 0;
        guard = 0;
        while (!done && guard < 200) begin @(negedge clk); guard++; end
        chk(done, "R7", "done seen", done, 1);
        if (wr) shadow[a] = d;
        else chk(rdata == shadow[a], "R6", "read data", rdata, shadow[a]);
        @(negedge clk);
        accepted = 0;
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
            do_op($urandom_range(0, 1) == 1, a, DATA_W'($urandom));
        end
    endtask

    task automatic switch_style(input logic s);
        style_stable = 0;
        repeat (30) @(negedge clk);
        style = s;
        repeat (30) @(negedge clk);
        style_stable = 1;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
    end

    initial begin
        int base;
        void'($urandom(32'h5A17));
        for (int i = 0; i < (1 << AW); i++) begin cells[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 15);
        chk(!done, "R1", "done low in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk(ready, "R1", "ready after reset", ready, 1);
        style_stable = 1;
        // directed corners: address extremes, write then immediate read, overwrite
        do_op(1, '0, 8'hA5);
        do_op(1, '1, 8'h3C);
        do_op(0, '0, 0);
        do_op(0, '1, 0);
        do_op(1, AW'(7), 8'h11);
        do_op(1, AW'(7), 8'h22);
        do_op(0, AW'(7), 0);
        random_ops(150);
        // quiet window: exact refresh spacing (R8) with row-only refresh (R9)
        base = ref_count;
        while (ref_count < base + 3) @(negedge clk);
        chk(last_gap == REF_INTERVAL, "R8", "idle refresh spacing", last_gap, REF_INTERVAL);
        switch_style(1);
        random_ops(150);
        base = ref_count;
        while (ref_count < base + 3) @(negedge clk);
        chk(last_gap == REF_INTERVAL, "R8", "idle column-first spacing", last_gap, REF_INTERVAL);
        switch_style(0);
        random_ops(60);
        for (int i = 0; i < 16; i++) do_op(0, AW'(i), 0);
        finish_run();
    end
endmodule